// File: doc/BRIEF.md
# Fixed Interval Timer Event Generator

The block raises a periodic timer event by watching one bit of a free-running time base low word. A two-bit period select chooses which bit is watched. Each time that bit goes from 0 to 1, the block sets a sticky status flag. Because a higher bit rises half as often as the bit below it, the select field sets the event period. The block reacts to the edge itself, not to the reason for it. A tick of the time base and a software write that turns the bit on are treated the same way.

Software clears the status flag by writing one to it. A separate enable gates the flag onto the interrupt line. The time base counter lives outside this block and arrives as an input word.

Top module: `fit_event_gen`

## Requirements
- R1: Select codes 0, 1, 2 and 3 watch time base bit TAP_BASE + code*TAP_STEP (LSB-0 numbering). With the defaults (TAP_BASE=12, TAP_STEP=4) these are bits 12, 16, 20 and 24, giving periods of 2^13, 2^17, 2^21 and 2^25 time base clocks.
- R2: When the watched bit is 0 at one rising clock edge and 1 at the next, `stat_o` is 1 after that second edge.
- R3: A watched bit that stays 0, stays 1, or falls from 1 to 0 does not set `stat_o`.
- R4: A jump of the time base word between any two values counts as an event whenever it takes the watched bit from 0 to 1.
- R5: Changes on bits other than the watched bit never set `stat_o`.
- R6: At a clock edge where `sel_i` differs from its value at the previous edge, no event is produced. The new bit is only captured as the reference for later edges.
- R7: Once set, `stat_o` stays 1 until an edge at which `clr_i` is 1.
- R8: When an event and `clr_i` fall on the same edge, `stat_o` is 1 after that edge.
- R9: `irq_o` equals `stat_o` AND `en_i` at all times. `en_i` takes effect in the same cycle.
- R10: While `rst_i` is 1, and after the first edge following its release, `stat_o` is 0 unless an event is due. The first edge after reset only captures the reference bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous reset, active high |
| tb_i | input | TB_W | Time base low word |
| sel_i | input | 2 | Period select code |
| en_i | input | 1 | Interrupt enable |
| clr_i | input | 1 | Write-one-to-clear strobe for the status flag |
| stat_o | output | 1 | Sticky event status |
| irq_o | output | 1 | Gated interrupt request |

## Verification
The bench builds the block with TB_W=16, TAP_BASE=1 and TAP_STEP=2, so the four taps are bits 1, 3, 5 and 7. At these values a free-running count produces events every 4, 16, 64 and 256 cycles. Every select code therefore shows several periods inside a short run. On top of the free-running count, the bench drives direct word jumps, select changes placed on edge cycles, and clears that coincide with events.

// File: rtl/fit_pkg.sv
package fit_pkg;
  localparam int SEL_W = 2;
  localparam int N_TAPS = 1 << SEL_W;

  typedef logic [SEL_W-1:0] fit_sel_t;

  // Bit index (LSB-0) watched for a given select code.
  function automatic int fit_tap_index(input int base, input int step, input int code);
    return base + code * step;
  endfunction

  // Next status value: an event sets, a clear drops, otherwise hold; set wins.
  function automatic logic fit_next_status(input logic cur, input logic evt, input logic clr);
    return evt | (cur & ~clr);
  endfunction
endpackage

// File: rtl/fit_tap_select.sv
module fit_tap_select
  import fit_pkg::*;
#(
  parameter int TB_W     = 32,
  parameter int TAP_BASE = 12,
  parameter int TAP_STEP = 4
) (
  input  logic [TB_W-1:0] tb_i,
  input  fit_sel_t        sel_i,
  output logic            bit_o
);
  localparam int TOP_TAP = TAP_BASE + (N_TAPS - 1) * TAP_STEP;

  logic [N_TAPS-1:0] taps;

  generate
    for (genvar g = 0; g < N_TAPS; g++) begin : g_tap
      localparam int IDX = TAP_BASE + g * TAP_STEP;
      assign taps[g] = tb_i[IDX];
    end
  endgenerate

  assign bit_o = taps[sel_i];

  initial begin
    tap_range_chk: assert (TOP_TAP < TB_W && fit_tap_index(TAP_BASE, TAP_STEP, N_TAPS - 1) == TOP_TAP)
      else $error("tap out of range");
  end
endmodule

// File: rtl/fit_edge_detect.sv
module fit_edge_detect
  import fit_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_i,
  input  logic     bit_i,
  input  fit_sel_t sel_i,
  output logic     evt_o
);
  logic     prev_q;
  fit_sel_t sel_q;
  logic     armed_q;
  logic     sel_same;

  assign sel_same = (sel_i == sel_q);
  assign evt_o    = armed_q & sel_same & ~prev_q & bit_i;

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      prev_q  <= 1'b0;
      sel_q   <= '0;
      armed_q <= 1'b0;
    end else begin
      prev_q  <= bit_i;
      sel_q   <= sel_i;
      armed_q <= 1'b1;
    end
  end

  // R6
  sel_change_quiet_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    (sel_i != $past(sel_i)) |-> !evt_o);

  // R3
  no_evt_from_high_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    ($past(bit_i) && (sel_i == $past(sel_i))) |-> !evt_o);
endmodule

// File: rtl/fit_status.sv
module fit_status
  import fit_pkg::*;
(
  input  logic clk_i,
  input  logic rst_i,
  input  logic evt_i,
  input  logic clr_i,
  input  logic en_i,
  output logic stat_o,
  output logic irq_o
);
  logic stat_q;

  always_ff @(posedge clk_i) begin
    if (rst_i) stat_q <= 1'b0;
    else       stat_q <= fit_next_status(stat_q, evt_i, clr_i);
  end

  assign stat_o = stat_q;
  assign irq_o  = stat_q & en_i;

  // R2
  evt_sets_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    evt_i |=> stat_q);

  // R7
  sticky_hold_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    (stat_q && !clr_i) |=> stat_q);

  // R8
  clear_drops_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    (clr_i && !evt_i) |=> !stat_q);
endmodule

// File: rtl/fit_event_gen.sv
module fit_event_gen
  import fit_pkg::*;
#(
  parameter int TB_W     = 32,
  parameter int TAP_BASE = 12,
  parameter int TAP_STEP = 4
) (
  input  logic            clk_i,
  input  logic            rst_i,
  input  logic [TB_W-1:0] tb_i,
  input  logic [1:0]      sel_i,
  input  logic            en_i,
  input  logic            clr_i,
  output logic            stat_o,
  output logic            irq_o
);
  logic tap_bit;
  logic fit_evt;

  fit_tap_select #(.TB_W(TB_W), .TAP_BASE(TAP_BASE), .TAP_STEP(TAP_STEP)) u_tap (
    .tb_i  (tb_i),
    .sel_i (sel_i),
    .bit_o (tap_bit)
  );

  fit_edge_detect u_edge (
    .clk_i (clk_i),
    .rst_i (rst_i),
    .bit_i (tap_bit),
    .sel_i (sel_i),
    .evt_o (fit_evt)
  );

  fit_status u_stat (
    .clk_i  (clk_i),
    .rst_i  (rst_i),
    .evt_i  (fit_evt),
    .clr_i  (clr_i),
    .en_i   (en_i),
    .stat_o (stat_o),
    .irq_o  (irq_o)
  );

  // R9
  irq_gated_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    irq_o |-> (en_i && stat_o));

  // R5
  other_bits_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    (!stat_o && $stable(tap_bit) && $stable(sel_i) && !$past(rst_i)) |=> !stat_o);
endmodule

// File: tb/fit_event_gen_bench.sv
module fit_event_gen_bench;
  localparam int TB_W = 16;

  logic            clk = 1'b0;
  logic            rst;
  logic [TB_W-1:0] tb;
  logic [1:0]      sel;
  logic            en;
  logic            clr;
  logic            stat;
  logic            irq;

  int    n_checks = 0;
  int    n_errors = 0;
  string tag = "R10";
  int    cycles = 0;

  // Reference model state.
  bit m_stat, m_prev, m_armed;
  bit [1:0] m_sel;

  always #4 clk = ~clk;

  fit_event_gen #(.TB_W(TB_W), .TAP_BASE(1), .TAP_STEP(2)) u_fit_event_gen (
    .clk_i(clk), .rst_i(rst), .tb_i(tb), .sel_i(sel),
    .en_i(en), .clr_i(clr), .stat_o(stat), .irq_o(irq)
  );

  // R1: taps 1,3,5,7 for this build, table written out independently.
  function automatic bit watched(input logic [TB_W-1:0] w, input logic [1:0] s);
    case (s)
      2'd0: return w[1];
      2'd1: return w[3];
      2'd2: return w[5];
      default: return w[7];
    endcase
  endfunction

  always @(posedge clk) begin
    bit cur, ev;
    cycles++;
    if (rst) begin
      m_stat = 0; m_prev = 0; m_armed = 0; m_sel = 0;
    end else begin
      cur = watched(tb, sel);
      ev  = m_armed && (sel == m_sel) && !m_prev && cur;
      if (ev) m_stat = 1;
      else if (clr) m_stat = 0;
      m_prev = cur; m_sel = sel; m_armed = 1;
    end
  end

  always @(negedge clk) begin
    n_checks++;
    if (stat !== m_stat) begin
      n_errors++;
      $display("FAIL %s stat actual=%b expected=%b t=%0t", tag, stat, m_stat, $time);
    end
    n_checks++;
    if (irq !== (m_stat & en)) begin
      n_errors++;
      $display("FAIL R9 irq actual=%b expected=%b t=%0t", irq, m_stat & en, $time);
    end
  end

  task automatic step(input logic [TB_W-1:0] w);
    tb = w;
    @(negedge clk);
  endtask

  task automatic clear_now();
    clr = 1; step(tb); clr = 0;
  endtask

  task automatic check_val(input string t, input bit expv);
    n_checks++;
    if (stat !== expv) begin
      n_errors++;
      $display("FAIL %s directed actual=%b expected=%b", t, stat, expv);
    end
  endtask

  initial begin
    rst = 1; tb = '0; sel = 0; en = 0; clr = 0;
    repeat (3) @(negedge clk);
    check_val("R10", 1'b0);
    // R10: watched bit already high at release: no event
    tb = 16'h0002; rst = 0;
    step(16'h0002); check_val("R10", 1'b0);
    // R1, R2: free count on each select
    for (int s = 0; s < 4; s++) begin
      tag = "R1";
      sel = s[1:0];
      step(tb);
      clear_now();
      for (int i = 0; i < 600; i++) begin
        step(tb + 1);
        if (stat) clear_now();
      end
    end
    // R2, R9: edge with enable
    tag = "R2"; en = 1; sel = 0; step(16'h0000); clear_now();
    step(16'h0002); check_val("R2", 1'b1);
    // R7: sticky over many cycles
    tag = "R7"; for (int i = 0; i < 10; i++) step(16'h0000);
    check_val("R7", 1'b1);
    en = 0; step(16'h0000); en = 1; step(16'h0000);
    clear_now(); check_val("R7", 1'b0);
    // R3: falling and steady
    tag = "R3"; step(16'h0002); clear_now(); step(16'h0000); step(16'h0000);
    check_val("R3", 1'b0);
    // R5: other bits toggle, watched bit 1 stays 0
    tag = "R5"; sel = 1; step(16'h0000);
    step(16'hFFF7); step(16'h0000); step(16'hFFF7); check_val("R5", 1'b0);
    // R4: jump sets bit 3
    tag = "R4"; step(16'h1234 & ~16'h0008); step(16'h4008); check_val("R4", 1'b1);
    clear_now();
    // R6: select changes on the same edge the new bit is high
    tag = "R6"; sel = 1; step(16'h0000);
    tb = 16'h0020; sel = 2; step(tb); check_val("R6", 1'b0);
    sel = 3; step(16'h0080); check_val("R6", 1'b0);
    step(16'h0000); step(16'h0080); check_val("R6", 1'b1);
    clear_now();
    // R8: event and clear together
    tag = "R8"; step(16'h0000); clr = 1; step(16'h0080); clr = 0;
    check_val("R8", 1'b1);
    clear_now(); check_val("R8", 1'b0);
    // R10: reset mid-run
    tag = "R10"; step(16'h0000); step(16'h0080);
    rst = 1; step(16'h0000); check_val("R10", 1'b0); rst = 0; step(16'h0080);
    check_val("R10", 1'b0);
    repeat (2) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin
    #400000;
    n_errors++; n_checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule